// File: doc/BRIEF.md
# Row Match Processor with Ternary, Range and Embedded-Data Entries

This block receives one row of stored entries and a search key in the same cycle. It compares the key against every entry of the row in parallel and reports the first entry that matches. The data field stored with that entry comes back together with the match result, so a lookup needs no second memory read. Hashing the key to a row and reading the row from memory are done upstream. The block only matches.

Each entry is judged as either a masked-value entry or an inclusive range entry. A per-entry configuration bit makes that choice. A key-select mask sets which key bits take part in any comparison, which sets the effective key width. A per-position ternary-enable mask decides, bit position by bit position, whether an entry's stored care bit is honoured or the bit is always compared. Entries are kept in the row in priority order, so the lowest-numbered matching entry wins. The logic runs in four steps:

1. Key expansion.
2. A per-entry match vector.
3. A priority decode of that vector.
4. Result extraction into a single output register.

Top module: `row_match_unit`

## Requirements
- R1: Entry i of the row occupies bits [i*EW +: EW], where EW = 2*KEY_W + DATA_W + 1. Within an entry, bits [KEY_W-1:0] hold the value (or low bound), bits [2*KEY_W-1:KEY_W] hold the care bits (or high bound), the next DATA_W bits hold data, and the top bit is a valid flag. An entry whose valid flag is 0 never matches.
- R2: In a masked-value entry, a key bit position with cfg_key_sel=1 and cfg_tern_en=0 matches only when the search key bit equals the stored value bit, whatever the stored care bit is.
- R3: In a masked-value entry, a position with cfg_key_sel=1 and cfg_tern_en=1 always matches when the stored care bit is 0, and matches only on equality when the care bit is 1.
- R4: Key bit positions with cfg_key_sel=0 have no effect on any entry. For range entries, the key, low bound and high bound are all taken with those bits cleared.
- R5: An entry with its cfg_range_en bit set to 1 matches when low <= key <= high, compared unsigned and inclusive at both ends. An entry with low > high never matches.
- R6: When several entries match, the result is the one with the lowest index.
- R7: On a hit, out_data is the data field of the winning entry when cfg_data_en=1, and 0 when cfg_data_en=0.
- R8: When in_valid is 1 and no entry matches, out_hit, out_idx and out_data are all 0 in the result.
- R9: The result appears one clock after the input: out_valid equals in_valid of the previous cycle. After a cycle with in_valid=0, out_hit, out_idx and out_data are 0.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Search request this cycle |
| search_key | input | KEY_W | Key to look up |
| row_bus | input | N_ENT*(2*KEY_W+DATA_W+1) | One row of entries |
| cfg_key_sel | input | KEY_W | 1 = key bit takes part in comparison |
| cfg_tern_en | input | KEY_W | 1 = stored care bit honoured at this position |
| cfg_range_en | input | N_ENT | 1 = entry is a range entry |
| cfg_data_en | input | 1 | 1 = return the embedded data |
| out_valid | output | 1 | Result valid |
| out_hit | output | 1 | An entry matched |
| out_idx | output | $clog2(N_ENT) | Index of the winning entry |
| out_data | output | DATA_W | Data of the winning entry |

## Verification
The assertions check the properties that hold on every cycle:

- The one-cycle relation between in_valid and out_valid.
- Quiet outputs after idle cycles.
- Zeroed index and data on a miss.
- A hit never pointing at an entry whose valid flag was clear.
- Data zeroed when embedding is off.

Which entry wins, and whether the masked, ternary and range comparisons judge each key correctly, can only be shown by the bench. It sweeps every key value over several row and configuration setups, including overlapping entries, range bounds that touch, empty ranges, and partly selected keys.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

    typedef enum logic {
        KIND_MASKED = 1'b0,
        KIND_RANGE  = 1'b1
    } entry_kind_e;

    function automatic int entry_width(input int key_w, input int data_w);
        return 2 * key_w + data_w + 1;
    endfunction

endpackage

// File: rtl/rmu_key_expand.sv
module rmu_key_expand #(
    parameter int KEY_W = 8
) (
    input  logic [KEY_W-1:0] key,
    input  logic [KEY_W-1:0] sel,
    input  logic [KEY_W-1:0] tern_en,
    output logic [KEY_W-1:0] key_m,
    output logic [KEY_W-1:0] bin_pos,
    output logic [KEY_W-1:0] tern_pos
);
    // step 1: restrict the key to the selected width and split positions
    always_comb begin
        key_m    = key & sel;
        bin_pos  = sel & ~tern_en;
        tern_pos = sel & tern_en;
    end
endmodule

// File: rtl/rmu_entry_cmp.sv
module rmu_entry_cmp
    import rmu_pkg::*;
#(
    parameter int KEY_W = 8
) (
    input  logic [KEY_W-1:0] key_m,
    input  logic [KEY_W-1:0] sel,
    input  logic [KEY_W-1:0] bin_pos,
    input  logic [KEY_W-1:0] tern_pos,
    input  logic [KEY_W-1:0] lo_val,
    input  logic [KEY_W-1:0] hi_care,
    input  logic             ent_vld,
    input  entry_kind_e      kind,
    output logic             match
);
    logic [KEY_W-1:0] care_eff;
    logic [KEY_W-1:0] lo_m;
    logic [KEY_W-1:0] hi_m;
    logic             hit_raw;

    // step 2: one bit of the match vector
    always_comb begin
        lo_m     = lo_val & sel;
        hi_m     = hi_care & sel;
        care_eff = bin_pos | (tern_pos & hi_care);
        if (kind == KIND_RANGE) begin
            hit_raw = (key_m >= lo_m) && (key_m <= hi_m);
        end else begin
            hit_raw = ((key_m ^ lo_val) & care_eff) == '0;
        end
        match = ent_vld & hit_raw;
    end
endmodule

// File: rtl/rmu_prio_dec.sv
module rmu_prio_dec #(
    parameter int N_ENT = 4,
    parameter int IDX_W = 2
) (
    input  logic [N_ENT-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // step 3: lowest set bit wins
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/row_match_unit.sv
module row_match_unit
    import rmu_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int KEY_W  = 8,
    parameter int DATA_W = 8,
    localparam int ENT_W  = 2 * KEY_W + DATA_W + 1,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int ROW_W  = N_ENT * ENT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [KEY_W-1:0]  search_key,
    input  logic [ROW_W-1:0]  row_bus,
    input  logic [KEY_W-1:0]  cfg_key_sel,
    input  logic [KEY_W-1:0]  cfg_tern_en,
    input  logic [N_ENT-1:0]  cfg_range_en,
    input  logic              cfg_data_en,
    output logic              out_valid,
    output logic              out_hit,
    output logic [IDX_W-1:0]  out_idx,
    output logic [DATA_W-1:0] out_data
);
    localparam int HI_OFF  = KEY_W;
    localparam int DAT_OFF = 2 * KEY_W;
    localparam int VLD_OFF = 2 * KEY_W + DATA_W;

    typedef struct packed {
        logic              vld;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } res_t;

    logic [KEY_W-1:0]  key_m;
    logic [KEY_W-1:0]  bin_pos;
    logic [KEY_W-1:0]  tern_pos;
    logic [N_ENT-1:0]  match_vec;
    logic [DATA_W-1:0] ent_data [N_ENT];
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    res_t              res_d;
    res_t              res_q;

    rmu_key_expand #(.KEY_W(KEY_W)) u_expand (
        .key      (search_key),
        .sel      (cfg_key_sel),
        .tern_en  (cfg_tern_en),
        .key_m    (key_m),
        .bin_pos  (bin_pos),
        .tern_pos (tern_pos)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic [ENT_W-1:0] ent;
        entry_kind_e      kind;
        assign ent         = row_bus[g*ENT_W +: ENT_W];
        assign ent_data[g] = ent[DAT_OFF +: DATA_W];
        assign kind        = cfg_range_en[g] ? KIND_RANGE : KIND_MASKED;

        rmu_entry_cmp #(.KEY_W(KEY_W)) u_cmp (
            .key_m    (key_m),
            .sel      (cfg_key_sel),
            .bin_pos  (bin_pos),
            .tern_pos (tern_pos),
            .lo_val   (ent[0 +: KEY_W]),
            .hi_care  (ent[HI_OFF +: KEY_W]),
            .ent_vld  (ent[VLD_OFF]),
            .kind     (kind),
            .match    (match_vec[g])
        );
    end

    rmu_prio_dec #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_dec (
        .vec (match_vec),
        .any (any_hit),
        .idx (win_idx)
    );

    // step 4: result extraction
    always_comb begin
        res_d      = '0;
        res_d.vld  = in_valid;
        res_d.hit  = in_valid & any_hit;
        if (res_d.hit) begin
            res_d.idx = win_idx;
            if (cfg_data_en) begin
                res_d.data = ent_data[win_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.vld;
    assign out_hit   = res_q.hit;
    assign out_idx   = res_q.idx;
    assign out_data  = res_q.data;
endmodule

// File: rtl/rmu_checker.sv
module rmu_checker #(
    parameter int N_ENT  = 4,
    parameter int KEY_W  = 8,
    parameter int DATA_W = 8,
    localparam int ENT_W = 2 * KEY_W + DATA_W + 1,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int ROW_W = N_ENT * ENT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ROW_W-1:0]  row_bus,
    input logic              cfg_data_en,
    input logic              out_valid,
    input logic              out_hit,
    input logic [IDX_W-1:0]  out_idx,
    input logic [DATA_W-1:0] out_data
);
    logic [N_ENT-1:0] vbits_q;
    logic             den_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbits_q <= '0;
            den_q   <= 1'b0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                vbits_q[i] <= row_bus[i*ENT_W + ENT_W - 1];
            end
            den_q <= cfg_data_en;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_hit && out_idx == '0 && out_data == '0)); // R9
    AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_hit) |-> (out_idx == '0 && out_data == '0)); // R8
    AST_HIT_ON_VALID_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> vbits_q[out_idx]); // R1
    AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !den_q) |-> out_data == '0); // R7
endmodule

bind row_match_unit rmu_checker #(
    .N_ENT  (N_ENT),
    .KEY_W  (KEY_W),
    .DATA_W (DATA_W)
) u_rmu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .row_bus     (row_bus),
    .cfg_data_en (cfg_data_en),
    .out_valid   (out_valid),
    .out_hit     (out_hit),
    .out_idx     (out_idx),
    .out_data    (out_data)
);

// File: tb/sim_row_match_unit.sv
`timescale 1ns/1ps
module sim_row_match_unit;
    localparam int N  = 4;
    localparam int K  = 8;
    localparam int D  = 8;
    localparam int EW = 2 * K + D + 1;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [K-1:0]    search_key = '0;
    logic [N*EW-1:0] row_bus = '0;
    logic [K-1:0]    cfg_key_sel = '1;
    logic [K-1:0]    cfg_tern_en = '0;
    logic [N-1:0]    cfg_range_en = '0;
    logic            cfg_data_en = 1'b1;
    logic            out_valid;
    logic            out_hit;
    logic [IW-1:0]   out_idx;
    logic [D-1:0]    out_data;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [K-1:0] e_lo [N];
    logic [K-1:0] e_hi [N];
    logic [D-1:0] e_dat [N];
    logic         e_v [N];

    always #4 clk = ~clk;

    row_match_unit #(.N_ENT(N), .KEY_W(K), .DATA_W(D)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .search_key(search_key),
        .row_bus(row_bus), .cfg_key_sel(cfg_key_sel), .cfg_tern_en(cfg_tern_en),
        .cfg_range_en(cfg_range_en), .cfg_data_en(cfg_data_en),
        .out_valid(out_valid), .out_hit(out_hit), .out_idx(out_idx), .out_data(out_data)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got {vld,hit,idx,data}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic load_row();
        for (int i = 0; i < N; i++) begin
            row_bus[i*EW +: EW] = {e_v[i], e_dat[i], e_hi[i], e_lo[i]};
        end
    endtask

    function automatic logic [11:0] model(input logic [K-1:0] key);
        logic [K-1:0] f, l, h;
        logic ok;
        for (int i = 0; i < N; i++) begin
            ok = e_v[i];
            if (cfg_range_en[i]) begin
                f = key & cfg_key_sel;
                l = e_lo[i] & cfg_key_sel;
                h = e_hi[i] & cfg_key_sel;
                if (f < l || f > h) ok = 1'b0;
            end else begin
                for (int j = 0; j < K; j++) begin
                    if (cfg_key_sel[j] && !(cfg_tern_en[j] && !e_hi[i][j])
                        && key[j] != e_lo[i][j]) ok = 1'b0;
                end
            end
            if (ok) return {1'b1, 1'b1, IW'(i), cfg_data_en ? e_dat[i] : 8'h00};
        end
        return {1'b1, 1'b0, 2'b00, 8'h00};
    endfunction

    task automatic sweep(input string req);
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            search_key = K'(k);
            in_valid = 1'b1;
            load_row();
            @(posedge clk);
            #1;
            check(req, {out_valid, out_hit, out_idx, out_data}, model(K'(k)));
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_ent(input int i, input logic v, input logic [K-1:0] lo,
                           input logic [K-1:0] hi, input logic [D-1:0] d);
        e_v[i] = v; e_lo[i] = lo; e_hi[i] = hi; e_dat[i] = d;
    endtask

    initial begin
        for (int i = 0; i < N; i++) set_ent(i, 1'b0, '0, '0, '0);
        #1;
        check("R10", {out_valid, out_hit, out_idx, out_data}, 12'h000);
        repeat (3) @(posedge clk);
        #1;
        check("R10", {out_valid, out_hit, out_idx, out_data}, 12'h000);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R6 R8: exact entries, duplicate value at index 1 and 3
        cfg_key_sel = 8'hFF; cfg_tern_en = 8'h00; cfg_range_en = 4'b0000; cfg_data_en = 1'b1;
        set_ent(0, 1, 8'h10, 8'h00, 8'hA1);
        set_ent(1, 1, 8'h20, 8'h0F, 8'hA2);
        set_ent(2, 1, 8'h30, 8'hFF, 8'hA3);
        set_ent(3, 1, 8'h20, 8'h00, 8'hA4);
        sweep("R2");

        // R7: data disabled
        cfg_data_en = 1'b0;
        sweep("R7");
        cfg_data_en = 1'b1;

        // R1: invalid entries never match
        e_v[1] = 1'b0; e_v[2] = 1'b0;
        sweep("R1");

        // R3 R6: ternary prefixes, longest first, catch-all last
        cfg_tern_en = 8'hFF;
        set_ent(0, 1, 8'h12, 8'hFF, 8'hB1);
        set_ent(1, 1, 8'h10, 8'hF0, 8'hB2);
        set_ent(2, 1, 8'h00, 8'h80, 8'hB3);
        set_ent(3, 1, 8'h00, 8'h00, 8'hB4);
        sweep("R3");

        // R2 R3 mixed: upper nibble always compared
        cfg_tern_en = 8'h0F;
        sweep("R6");

        // R4: only upper nibble selected
        cfg_tern_en = 8'h00; cfg_key_sel = 8'hF0;
        set_ent(0, 1, 8'h3A, 8'h00, 8'hC1);
        set_ent(1, 1, 8'h55, 8'h00, 8'hC2);
        set_ent(2, 1, 8'hF0, 8'h00, 8'hC3);
        set_ent(3, 1, 8'h5F, 8'h00, 8'hC4);
        sweep("R4");

        // R5: inclusive ranges, touching bounds, empty range, exact entry
        cfg_key_sel = 8'hFF; cfg_range_en = 4'b0111; cfg_tern_en = 8'hFF;
        set_ent(0, 1, 8'h40, 8'h4F, 8'hD1);
        set_ent(1, 1, 8'h4F, 8'h60, 8'hD2);
        set_ent(2, 1, 8'h90, 8'h80, 8'hD3);
        set_ent(3, 1, 8'hFF, 8'hFF, 8'hD4);
        sweep("R5");

        // R4 R5: range on low nibble only
        cfg_key_sel = 8'h0F; cfg_range_en = 4'b1111;
        set_ent(0, 1, 8'hF3, 8'h05, 8'hE1);
        set_ent(1, 1, 8'h00, 8'h00, 8'hE2);
        set_ent(2, 1, 8'h0A, 8'hAF, 8'hE3);
        set_ent(3, 0, 8'h00, 8'hFF, 8'hE4);
        sweep("R5");

        // R9: idle cycles produce no result
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            search_key = 8'h01;
            @(posedge clk);
            #1;
            check("R9", {out_valid, out_hit, out_idx, out_data}, 12'h000);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule